// File: doc/BRIEF.md
# Multi-Lane Stream Integrity Checker

This block sits at the receive end of a multi-lane streaming link and judges the test traffic that a matching pattern generator placed on the lanes. Each lane carries one 64-bit sample word per beat. A sample word packs three fields: a lane identifier, a burst number and a running word number. On every beat that is both valid and enabled, the checker tests every lane in parallel. The identifier must match the lane's position. The word number must keep rising. The burst number must step only where a burst starts. Every lane must agree with its neighbour, which shows that deskew worked.

Failures fall into three classes: swap (wrong identifier), sequence (word or burst numbering broken) and alignment (lanes disagree). Each class has a sticky flag and a saturating 16-bit counter. A separate counter records how many beats were judged. The checker has its own active-low reset, apart from the generator's reset. A one-cycle clear input zeroes all flags and counters without touching the stored reference values.

Top module: `lane_stream_checker`

## Requirements
- R1: On a checked beat, lane i whose bits 63..59 differ from i raises a swap error for that beat.
- R2: On a checked beat with the lane primed, a word number (bits 31..0, unsigned) not strictly greater than that lane's stored word number raises a sequence error.
- R3: On a checked beat with the lane primed, the burst number (bits 58..32, unsigned) must exceed the stored one when start_of_burst is high and must equal it when start_of_burst is low; otherwise a sequence error is raised.
- R4: On a checked beat, lane i whose word number or burst number differs from that of lane (i+1) mod LANES raises an alignment error.
- R5: The first checked beat after reset, or after enable has been low, only loads the stored references and raises no sequence error.
- R6: A beat is checked only when valid and enable are both high; other cycles change no flag or counter and leave the stored references unchanged.
- R7: Errors found on a beat sampled at clock edge k appear on the flags and counters after edge k+1 and not before.
- R8: An error flag, once set, stays high until clear or reset.
- R9: Each class counter adds one per checked beat with at least one lane of that class failing, and holds at 65535.
- R10: A clear pulse zeroes all three flags, all three class counters and the beat counter at the next edge.
- R11: The beat counter adds one per checked beat, with the same latency as R7.
- R12: After reset all flags and counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset for the checker |
| enable | input | 1 | Checking enable; while low, the lanes are unprimed |
| clear | input | 1 | One-cycle clear of flags and counters |
| lane_data | input | LANES*64 | Sample words; lane i sits in bits [64*i+63 : 64*i] |
| valid | input | 1 | Beat qualifier |
| sob | input | 1 | Start of burst for this beat |
| swap_flag | output | 1 | Sticky lane-identifier error |
| seq_flag | output | 1 | Sticky numbering error |
| align_flag | output | 1 | Sticky lane-disagreement error |
| swap_count | output | 16 | Saturating count of beats with a swap error |
| seq_count | output | 16 | Saturating count of beats with a sequence error |
| align_count | output | 16 | Saturating count of beats with an alignment error |
| beat_count | output | 32 | Saturating count of checked beats |

## Verification
A corrupted stored reference does not show on any output until the next checked beat on that lane. It then appears as a false or missing sequence error two edges later. For that reason the bench follows every ignored stretch and every disabled stretch with a clean beat that is judged against the stored values. A wrong priming state shows on the first beat after reset or after re-enabling. A broken counter or flag register shows at the first output sample after the beat. That sample is taken on every beat in the random phase, and after a run of back-to-back beats long enough to reach saturation.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  // Sample word layout; a neighbour generator encodes the same positions.
  localparam int WORD_W   = 64;
  localparam int ID_LO    = 59;
  localparam int ID_W     = 5;
  localparam int BURST_LO = 32;
  localparam int BURST_W  = 27;
  localparam int WCNT_LO  = 0;
  localparam int WCNT_W   = 32;

  localparam int NUM_CLS  = 3;
  typedef enum logic [1:0] {CLS_SWAP = 2'd0, CLS_SEQ = 2'd1, CLS_ALIGN = 2'd2} err_cls_e;
endpackage

// File: rtl/lsc_lane_check.sv
module lsc_lane_check
  import lsc_pkg::*;
#(
  parameter int LANE_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk,
  input  logic              unprime,
  input  logic              sob,
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] nbr_word,
  output logic              swap_err,
  output logic              seq_err,
  output logic              align_err
);

  logic [ID_W-1:0]    id;
  logic [BURST_W-1:0] burst, nbr_burst, ref_burst, ref_burst_d;
  logic [WCNT_W-1:0]  wcnt, nbr_wcnt, ref_wcnt, ref_wcnt_d;
  logic               primed, primed_d;
  logic               word_bad, burst_bad;

  always_comb begin
    id        = word[ID_LO +: ID_W];
    burst     = word[BURST_LO +: BURST_W];
    wcnt      = word[WCNT_LO +: WCNT_W];
    nbr_burst = nbr_word[BURST_LO +: BURST_W];
    nbr_wcnt  = nbr_word[WCNT_LO +: WCNT_W];
    word_bad  = (wcnt <= ref_wcnt);
    burst_bad = sob ? (burst <= ref_burst) : (burst != ref_burst);
    swap_err  = chk && (id != ID_W'(LANE_IDX));
    seq_err   = chk && primed && (word_bad || burst_bad);
    align_err = chk && ((wcnt != nbr_wcnt) || (burst != nbr_burst));
  end

  always_comb begin
    ref_wcnt_d  = ref_wcnt;
    ref_burst_d = ref_burst;
    primed_d    = primed;
    if (chk) begin
      ref_wcnt_d  = wcnt;
      ref_burst_d = burst;
      primed_d    = 1'b1;
    end
    if (unprime) primed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_wcnt  <= '0;
      ref_burst <= '0;
      primed    <= 1'b0;
    end else begin
      ref_wcnt  <= ref_wcnt_d;
      ref_burst <= ref_burst_d;
      primed    <= primed_d;
    end
  end

  // R6: references only move on a checked beat
  assert_ref_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !chk |=> ($stable(ref_wcnt) && $stable(ref_burst)));
  // R5: leaving the enabled state drops the priming
  assert_unprime_R5: assert property (@(posedge clk) disable iff (!rst_n)
    unprime |=> !primed);
endmodule

// File: rtl/lsc_err_accum.sv
module lsc_err_accum #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             clr,
  output logic             flag,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             flag_d;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    flag_d = flag;
    cnt_d  = cnt;
    if (clr) begin
      flag_d = 1'b0;
      cnt_d  = '0;
    end else if (hit) begin
      flag_d = 1'b1;
      if (cnt != CNT_MAX) cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      cnt  <= '0;
    end else begin
      flag <= flag_d;
      cnt  <= cnt_d;
    end
  end

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));
  assert_no_hit_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !hit) |=> $stable(cnt));
  assert_hit_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr) |=> (flag && cnt != '0));
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !flag));
endmodule

// File: rtl/lane_stream_checker.sv
module lane_stream_checker
  import lsc_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int CNT_W  = 16,
  parameter int BEAT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    clear,
  input  logic [LANES*WORD_W-1:0] lane_data,
  input  logic                    valid,
  input  logic                    sob,
  output logic                    swap_flag,
  output logic                    seq_flag,
  output logic                    align_flag,
  output logic [CNT_W-1:0]        swap_count,
  output logic [CNT_W-1:0]        seq_count,
  output logic [CNT_W-1:0]        align_count,
  output logic [BEAT_W-1:0]       beat_count
);
  localparam logic [BEAT_W-1:0] BEAT_MAX = '1;

  logic               chk;
  logic [LANES-1:0]   swap_l, seq_l, align_l;
  logic [NUM_CLS-1:0] err_now, err_q;
  logic               beat_q;
  logic [BEAT_W-1:0]  beat_d;
  logic [NUM_CLS-1:0] flags;
  logic [CNT_W-1:0]   counts [NUM_CLS];

  assign chk = valid && enable;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lsc_lane_check #(.LANE_IDX(i)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .chk       (chk),
      .unprime   (!enable),
      .sob       (sob),
      .word      (lane_data[i*WORD_W +: WORD_W]),
      .nbr_word  (lane_data[((i+1) % LANES)*WORD_W +: WORD_W]),
      .swap_err  (swap_l[i]),
      .seq_err   (seq_l[i]),
      .align_err (align_l[i])
    );
  end

  always_comb begin
    err_now            = '0;
    err_now[CLS_SWAP]  = |swap_l;
    err_now[CLS_SEQ]   = |seq_l;
    err_now[CLS_ALIGN] = |align_l;
  end

  // judgement register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      beat_q <= 1'b0;
    end else begin
      err_q  <= err_now;
      beat_q <= chk;
    end
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    lsc_err_accum #(.CNT_W(CNT_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (err_q[c]),
      .clr   (clear),
      .flag  (flags[c]),
      .cnt   (counts[c])
    );
  end

  always_comb begin
    beat_d = beat_count;
    if (clear)                               beat_d = '0;
    else if (beat_q && beat_count != BEAT_MAX) beat_d = beat_count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_count <= '0;
    else        beat_count <= beat_d;
  end

  assign swap_flag   = flags[CLS_SWAP];
  assign seq_flag    = flags[CLS_SEQ];
  assign align_flag  = flags[CLS_ALIGN];
  assign swap_count  = counts[CLS_SWAP];
  assign seq_count   = counts[CLS_SEQ];
  assign align_count = counts[CLS_ALIGN];

  // R6: an unchecked cycle produces no judgement pulse
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !chk |=> (!beat_q && err_q == '0));
  // R7: an error pulse always comes with a beat pulse
  assert_err_needs_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != '0) |-> beat_q);
  // R11: the beat counter moves by at most one per cycle
  assert_beat_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (beat_count == $past(beat_count) || beat_count == $past(beat_count) + 1'b1));
  // R10: clear zeroes the beat counter
  assert_beat_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (beat_count == '0));
endmodule

// File: tb/lane_stream_checker_bench.sv
module lane_stream_checker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int W = 64;
  localparam int CMAX = 65535;

  logic clk = 1'b0;
  logic rst_n, enable, clear, valid, sob;
  logic [LANES*W-1:0] lane_data;
  logic swap_flag, seq_flag, align_flag;
  logic [15:0] swap_count, seq_count, align_count;
  logic [31:0] beat_count;

  lane_stream_checker #(.LANES(LANES)) u_lane_stream_checker (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
    .lane_data(lane_data), .valid(valid), .sob(sob),
    .swap_flag(swap_flag), .seq_flag(seq_flag), .align_flag(align_flag),
    .swap_count(swap_count), .seq_count(seq_count), .align_count(align_count),
    .beat_count(beat_count));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  bit          m_primed;
  logic [31:0] m_w [LANES];
  logic [26:0] m_b [LANES];
  int e_swap, e_seq, e_align, e_beats;
  bit f_swap, f_seq, f_align;

  // generator state
  logic [31:0] gw;
  logic [26:0] gb;

  function automatic logic [63:0] mk(input int id, input logic [26:0] b, input logic [31:0] w);
    return {5'(id), b, w};
  endfunction

  function automatic logic [LANES*W-1:0] clean_beat(input logic [26:0] b, input logic [31:0] w);
    logic [LANES*W-1:0] d;
    for (int i = 0; i < LANES; i++) d[i*W +: W] = mk(i, b, w);
    return d;
  endfunction

  function automatic int sat_inc(input int v);
    return (v < CMAX) ? v + 1 : v;
  endfunction

  task automatic model(input logic [LANES*W-1:0] d, input logic s);
    bit sw = 0, sq = 0, al = 0;
    for (int i = 0; i < LANES; i++) begin
      logic [4:0]  id = d[i*W+59 +: 5];
      logic [26:0] b  = d[i*W+32 +: 27];
      logic [31:0] w  = d[i*W +: 32];
      int j = (i + 1) % LANES;
      if (id != 5'(i)) sw = 1;
      if (m_primed) begin
        if (w <= m_w[i]) sq = 1;
        if (s && b <= m_b[i]) sq = 1;
        if (!s && b != m_b[i]) sq = 1;
      end
      if (w != d[j*W +: 32] || b != d[j*W+32 +: 27]) al = 1;
    end
    for (int i = 0; i < LANES; i++) begin
      m_w[i] = d[i*W +: 32];
      m_b[i] = d[i*W+32 +: 27];
    end
    m_primed = 1;
    e_beats++;
    if (sw) begin e_swap = sat_inc(e_swap); f_swap = 1; end
    if (sq) begin e_seq = sat_inc(e_seq); f_seq = 1; end
    if (al) begin e_align = sat_inc(e_align); f_align = 1; end
  endtask

  task automatic check(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    string act, exp;
    act = $sformatf("flags=%0b%0b%0b cnt=%0d/%0d/%0d beats=%0d",
                    swap_flag, seq_flag, align_flag, swap_count, seq_count, align_count, beat_count);
    exp = $sformatf("flags=%0b%0b%0b cnt=%0d/%0d/%0d beats=%0d",
                    f_swap, f_seq, f_align, e_swap, e_seq, e_align, e_beats);
    check(act == exp, req, act, exp);
  endtask

  // one checked beat, outputs compared after the second edge
  task automatic beat(input logic [LANES*W-1:0] d, input logic s, input string req);
    @(negedge clk);
    lane_data = d; sob = s; valid = 1'b1;
    model(d, s);
    @(negedge clk);
    valid = 1'b0;
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    e_swap = 0; e_seq = 0; e_align = 0; e_beats = 0;
    f_swap = 0; f_seq = 0; f_align = 0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    logic [LANES*W-1:0] d;
    string s0, s1;
    void'($urandom(32'd20240611));
    rst_n = 0; enable = 0; clear = 0; valid = 0; sob = 0; lane_data = '0;
    m_primed = 0; e_swap = 0; e_seq = 0; e_align = 0; e_beats = 0;
    f_swap = 0; f_seq = 0; f_align = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare_all("R12 reset state");
    enable = 1;

    // R5: first beat after reset with arbitrary counters
    gb = 27'd500; gw = 32'd70000;
    beat(clean_beat(gb, gw), 1'b0, "R5 first beat loads only");

    // R7 latency on a swap error, R1
    gw = gw + 1;
    d = clean_beat(gb, gw);
    d[2*W+59 +: 5] = 5'd1;
    @(negedge clk);
    lane_data = d; sob = 0; valid = 1;
    model(d, 1'b0);
    @(negedge clk);
    valid = 0;
    s0 = $sformatf("%0b/%0d/%0d", swap_flag, swap_count, beat_count);
    check(swap_flag == 0 && swap_count == 0 && beat_count == 1, "R7 no result after first edge", s0, "0/0/1");
    @(negedge clk);
    compare_all("R7 R1 swap after second edge");

    // R2 repeated and lower word numbers
    beat(clean_beat(gb, gw), 1'b0, "R2 repeated word number");
    beat(clean_beat(gb, gw - 5), 1'b0, "R2 lower word number");
    gw = gw + 10;
    beat(clean_beat(gb, gw), 1'b0, "R2 clean increase");

    // R3 burst rules
    gw = gw + 1;
    beat(clean_beat(gb, gw), 1'b1, "R3 sob without burst step");
    gw = gw + 1; gb = gb + 1;
    beat(clean_beat(gb, gw), 1'b0, "R3 burst change without sob");
    gw = gw + 1; gb = gb + 3;
    beat(clean_beat(gb, gw), 1'b1, "R3 sob with burst step");

    // R4 alignment: burst only on last lane, word only on lane 0
    gw = gw + 1;
    d = clean_beat(gb, gw);
    d[3*W+32 +: 27] = gb + 1;
    beat(d, 1'b0, "R4 burst mismatch last lane");
    gw = gw + 2;
    d = clean_beat(gb, gw);
    d[0 +: 32] = gw + 1;
    beat(d, 1'b0, "R4 word mismatch lane 0");

    // R6: invalid garbage cycles, then clean beat judged against stored refs
    @(negedge clk);
    lane_data = '1; sob = 1;
    repeat (4) @(negedge clk);
    compare_all("R6 invalid cycles ignored");
    gw = gw + 2;
    beat(clean_beat(gb, gw), 1'b0, "R6 refs untouched by invalid cycles");

    // R6/R5: disabled valid beats ignored, re-enable primes fresh
    enable = 0;
    m_primed = 0;
    @(negedge clk);
    lane_data = clean_beat(gb, 32'd3); valid = 1;
    repeat (3) @(negedge clk);
    valid = 0;
    @(negedge clk);
    compare_all("R6 disabled beats ignored");
    enable = 1;
    beat(clean_beat(gb - 2, 32'd5), 1'b0, "R5 re-enable first beat no sequence error");
    gw = 32'd6;
    beat(clean_beat(gb - 2, gw), 1'b0, "R8 flags stay set on clean beat");
    gb = gb - 2;

    // R10 clear
    do_clear();
    @(negedge clk);
    compare_all("R10 clear zeroes all");

    // random phase
    for (int n = 0; n < 300; n++) begin
      int kind = $urandom_range(0, 9);
      int ln = $urandom_range(0, LANES - 1);
      logic s = ($urandom_range(0, 7) == 0);
      if (kind != 2) gw = gw + 32'($urandom_range(1, 3));
      if (s && kind != 5) gb = gb + 27'($urandom_range(1, 2));
      if (kind == 4) gb = gb + 1;
      d = clean_beat(gb, gw);
      if (kind == 1) d[ln*W+59 +: 5] = 5'($urandom_range(0, 31));
      if (kind == 3) d[ln*W +: 32] = gw + 32'($urandom_range(1, 2));
      if (kind == 6) d[ln*W+32 +: 27] = gb ^ 27'($urandom_range(1, 7));
      beat(d, s, "R1 R2 R3 R4 R9 random beat");
    end

    // R9 saturation with back-to-back beats
    do_clear();
    d = clean_beat(gb, gw);
    d[W+59 +: 5] = 5'd0;
    @(negedge clk);
    lane_data = d; sob = 0; valid = 1;
    for (int n = 0; n < CMAX + 6; n++) begin
      model(d, 1'b0);
      @(negedge clk);
    end
    valid = 0;
    @(negedge clk);
    @(negedge clk);
    s1 = $sformatf("%0d/%0d", swap_count, seq_count);
    check(swap_count == 16'hFFFF && seq_count == 16'hFFFF, "R9 saturation", s1, "65535/65535");
    compare_all("R9 R11 after saturation run");
    report();
  end
endmodule